// File: doc/BRIEF.md
# Lamp-Current DAC Register Slave on a Two-Wire Bus

This block is a write-only slave on a two-wire SMBus. It holds the 6-bit code of a current-output DAC and a shutdown flag. A fast system clock oversamples the bus clock and data lines. Each line passes through a synchroniser and a short glitch filter, and the filtered lines are decoded into START, STOP and clock-edge events.

A host writes to the block with a Write Byte transaction: an address byte, a command byte and a data byte. The block acknowledges each of the three bytes by pulling the data line low, through an open-drain request output. The shutdown flag is taken when the command acknowledge ends. The DAC code is taken when the data acknowledge ends. So a transaction cut short by a STOP never changes the code.

A strap input picks one of two slave addresses, and it also picks the code loaded at power-up. A suspend input (active low) is ORed with the shutdown flag. The result drives a suspend output and an open-drain request to pull the regulator enable line low. The DAC code is kept through suspend.

Top module: `lampdac_smb_slave`

## Requirements
- R1: In reset the DAC code takes its power-up value: 000000 when `strap_i`=0 and 100000 when `strap_i`=1. The shutdown flag, `suspend_o` and `sda_pull_o` are all 0.
- R2: The block answers only the 7-bit address {01011, 0, `strap_i`} followed by a write bit of 0. The address bits are sent MSB first, with the read/write bit last. Any other address, or a read bit of 1, gets no acknowledge, and the bus is then ignored until the next START.
- R3: `sda_pull_o` is 1 only inside an acknowledge slot. It rises after the SCL falling edge that ends the 8th bit of a byte, and it drops after the next SCL falling edge. It is 0 while bits are being shifted in.
- R4: Bit 7 of the command byte (1 = shut down) is stored as the shutdown flag when the command acknowledge ends. Command bits 6..0 have no effect.
- R5: Data byte bits 7..2 become the DAC code, with bit 7 as the code MSB, when the data acknowledge ends. Data bits 1..0 have no effect.
- R6: A STOP at any point returns the block to idle. A STOP before the data acknowledge has ended leaves the DAC code unchanged.
- R7: A START, including a repeated START in the middle of a byte, throws away any partial transfer and begins receiving a new address.
- R8: `suspend_o` and `regoff_pull_o` are 1 when `suspend_n_i` is low or the shutdown flag is 1, and 0 otherwise. The DAC code is unchanged by entering or leaving suspend.
- R9: A pulse on SCL or SDA lasting fewer than 3 system clocks has no effect on the bus state.
- R10: Data is sampled on rising SCL. Bytes that follow an acknowledged data byte are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-up reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Selects the address LSB and the power-up code |
| suspend_n_i | input | 1 | Active-low suspend request |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| dac_code_o | output | 6 | Current DAC code |
| shut_bit_o | output | 1 | Stored shutdown flag |
| suspend_o | output | 1 | Suspend mode active |
| regoff_pull_o | output | 1 | 1 = pull the regulator enable line low |

## Verification
Directed transactions cover the following cases. A clean write at each strap setting checks both address decodes and both power-up codes. A wrong address and a read bit show the decode rejects near misses. STOPs after the address byte and after the command byte separate the two latch points. A repeated START in the middle of a data byte shows partial bytes are discarded. Short glitches on both lines, placed inside a data byte, show the filter is what keeps the byte intact. A seeded random mix then varies the address, the command and data values, and the point of an early STOP. Each result is compared with a bench model of which latch points the transaction reached. The suspend pin is toggled against both values of the shutdown flag.

// File: rtl/lampdac_smb_pkg.sv
package lampdac_smb_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_UPPER = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_DATA,
        ST_ACK_DATA
    } fsm_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    // Seven-bit slave address: fixed upper part, strap on the LSB.
    function automatic logic [6:0] own_addr(input logic strap);
        return {ADDR_UPPER, 1'b0, strap};
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            // The output moves only when every stored sample agrees.
            if (&hist_q)
                clean_q <= 1'b1;
            else if (~|hist_q)
                clean_q <= 1'b0;
        end
    end

    assign clean_o = clean_q;
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import lampdac_smb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start    = scl_q & scl_i & sda_q & ~sda_i;
        ev_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
        ev_o.scl_rise = ~scl_q & scl_i;
        ev_o.scl_fall = scl_q & ~scl_i;
        ev_o.sda      = sda_i;
    end
endmodule

// File: rtl/smb_write_fsm.sv
module smb_write_fsm
    import lampdac_smb_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              strap_i,
    output fsm_state_t        state_o,
    output logic              pull_o,
    output logic              shut_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    fsm_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              pull_q;
    logic              shut_q;
    logic [CODE_W-1:0] code_q;
    logic              in_byte;
    logic              addr_hit;

    assign in_byte  = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
    assign addr_hit = (shreg_q[BYTE_W-1:1] == own_addr(strap_i)) && !shreg_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            pull_q  <= 1'b0;
            shut_q  <= 1'b0;
            code_q  <= strap_i ? MID_CODE : '0;
        end else if (ev_i.start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (ev_i.stop) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (in_byte) begin
            if (ev_i.scl_rise && cnt_q != FULL_CNT) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], ev_i.sda};
                cnt_q   <= cnt_q + 1'b1;
            end else if (ev_i.scl_fall && cnt_q == FULL_CNT) begin
                cnt_q <= '0;
                unique case (state_q)
                    ST_ADDR: begin
                        if (addr_hit) begin
                            state_q <= ST_ACK_ADDR;
                            pull_q  <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_CMD: begin
                        state_q <= ST_ACK_CMD;
                        pull_q  <= 1'b1;
                    end
                    default: begin
                        state_q <= ST_ACK_DATA;
                        pull_q  <= 1'b1;
                    end
                endcase
            end
        end else if (ev_i.scl_fall) begin
            unique case (state_q)
                ST_ACK_ADDR: begin
                    state_q <= ST_CMD;
                    pull_q  <= 1'b0;
                end
                ST_ACK_CMD: begin
                    state_q <= ST_DATA;
                    pull_q  <= 1'b0;
                    shut_q  <= shreg_q[BYTE_W-1];
                end
                ST_ACK_DATA: begin
                    state_q <= ST_IDLE;
                    pull_q  <= 1'b0;
                    code_q  <= shreg_q[BYTE_W-1 -: CODE_W];
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign pull_o  = pull_q;
    assign shut_o  = shut_q;
    assign code_o  = code_q;
endmodule

// File: rtl/lampdac_smb_slave.sv
module lampdac_smb_slave
    import lampdac_smb_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    input  logic              suspend_n_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              shut_bit_o,
    output logic              suspend_o,
    output logic              regoff_pull_o
);
    logic       scl_clean, sda_clean;
    bus_ev_t    bus_ev;
    fsm_state_t fsm_state;
    logic [SYNC_STAGES-1:0] sus_sync_q;
    logic       suspend_q;

    smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst(rst), .raw_i(scl_i), .clean_o(scl_clean)
    );

    smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst(rst), .raw_i(sda_i), .clean_o(sda_clean)
    );

    smb_bus_events u_events (
        .clk(clk), .rst(rst), .scl_i(scl_clean), .sda_i(sda_clean), .ev_o(bus_ev)
    );

    smb_write_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst(rst), .ev_i(bus_ev), .strap_i(strap_i),
        .state_o(fsm_state), .pull_o(sda_pull_o),
        .shut_o(shut_bit_o), .code_o(dac_code_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sus_sync_q <= '1;
            suspend_q  <= 1'b0;
        end else begin
            sus_sync_q <= {sus_sync_q[SYNC_STAGES-2:0], suspend_n_i};
            suspend_q  <= ~sus_sync_q[SYNC_STAGES-1] | shut_bit_o;
        end
    end

    assign suspend_o     = suspend_q;
    assign regoff_pull_o = suspend_q;
endmodule

// File: rtl/lampdac_smb_chk.sv
module lampdac_smb_chk
    import lampdac_smb_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input fsm_state_t        state,
    input bus_ev_t           ev,
    input logic              sda_pull_o,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              shut_bit_o,
    input logic              suspend_o,
    input logic              regoff_pull_o
);
    // R3
    pull_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> (state == ST_ACK_ADDR || state == ST_ACK_CMD || state == ST_ACK_DATA));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_ACK_DATA && ev.scl_fall) |=> $stable(dac_code_o));

    // R4
    shut_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_ACK_CMD && ev.scl_fall) |=> $stable(shut_bit_o));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && !sda_pull_o));

    // R6
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_pull_o));

    // R8
    regoff_match_chk: assert property (@(posedge clk) disable iff (rst)
        regoff_pull_o == suspend_o);

    // R8
    shut_suspend_chk: assert property (@(posedge clk) disable iff (rst)
        shut_bit_o |=> suspend_o);
endmodule

bind lampdac_smb_slave lampdac_smb_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .state(fsm_state), .ev(bus_ev),
    .sda_pull_o(sda_pull_o), .dac_code_o(dac_code_o), .shut_bit_o(shut_bit_o),
    .suspend_o(suspend_o), .regoff_pull_o(regoff_pull_o)
);

// File: tb/lampdac_smb_slave_tb.sv
module lampdac_smb_slave_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sus_n = 1'b1;
    logic sda_line;
    logic sda_pull, shut_bit, suspend, regoff;
    logic [5:0] code;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_code;
    logic       exp_shut;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    lampdac_smb_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .suspend_n_i(sus_n), .sda_pull_o(sda_pull),
        .dac_code_o(code), .shut_bit_o(shut_bit), .suspend_o(suspend),
        .regoff_pull_o(regoff)
    );

    function automatic logic [5:0] default_code(input logic s);
        return s ? 6'b100000 : 6'b000000;
    endfunction

    function automatic logic [7:0] addr_byte(input logic s, input logic rd);
        return {5'b01011, 1'b0, s, rd};
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        strap = s;
        scl_m = 1'b1;
        sda_m = 1'b1;
        rst = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(10);
        exp_code = default_code(s);
        exp_shut = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        cyc(Q);
        scl_m = 1'b1;
        cyc(Q);
        sda_m = 1'b0;
        cyc(Q);
        scl_m = 1'b0;
        cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        cyc(Q);
        scl_m = 1'b1;
        cyc(Q);
        sda_m = 1'b1;
        cyc(3 * Q);
    endtask

    // glitch_bit: index (7..0) of a bit whose high phase gets short pulses; -1 none
    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            cyc(Q);
            scl_m = 1'b1;
            cyc(Q);
            if (i == glitch_bit) begin
                sda_m = ~b[i];
                cyc(2);
                sda_m = b[i];
                cyc(4);
                scl_m = 1'b0;
                cyc(2);
                scl_m = 1'b1;
                cyc(4);
            end
            chk("R3 no pull while shifting", {31'd0, sda_pull}, 32'd0);
            cyc(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1;
        cyc(Q);
        scl_m = 1'b1;
        cyc(Q);
        ack = ~sda_line;
        cyc(Q);
        scl_m = 1'b0;
        cyc(Q);
    endtask

    task automatic check_state(input string req);
        chk({req, " code"}, {26'd0, code}, {26'd0, exp_code});
        chk({req, " shut"}, {31'd0, shut_bit}, {31'd0, exp_shut});
    endtask

    // Full or truncated write; stop_after: 1 addr, 2 cmd, 3 data
    task automatic write_txn(input logic [7:0] ab, input logic [7:0] cb,
                             input logic [7:0] db, input int stop_after,
                             input logic exp_hit, input string req);
        logic a;
        bus_start();
        send_byte(ab, -1, a);
        chk({req, " addr ack"}, {31'd0, a}, {31'd0, exp_hit});
        if (exp_hit && stop_after >= 2) begin
            send_byte(cb, -1, a);
            chk({req, " cmd ack"}, {31'd0, a}, 32'd1);
            exp_shut = cb[7];
            if (stop_after >= 3) begin
                send_byte(db, -1, a);
                chk({req, " data ack"}, {31'd0, a}, 32'd1);
                exp_code = db[7:2];
            end
        end
        bus_stop();
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] cb, db, ab;
        int sp;
        logic hit;
        void'($urandom(32'd7341));

        // R1 power-up values for both straps
        rst = 1'b1;
        strap = 1'b0;
        cyc(5);
        chk("R1 code strap0", {26'd0, code}, 32'd0);
        chk("R1 pull in reset", {31'd0, sda_pull}, 32'd0);
        chk("R1 suspend in reset", {31'd0, suspend}, 32'd0);
        do_reset(1'b1);
        chk("R1 code strap1", {26'd0, code}, 32'h20);
        chk("R1 shut strap1", {31'd0, shut_bit}, 32'd0);

        // R2 R5 R4 full writes at strap 1, command low bits ignored
        write_txn(addr_byte(1'b1, 1'b0), 8'h7F, 8'hB7, 3, 1'b1, "R5 write strap1");
        chk("R5 code value", {26'd0, code}, 32'h2D);
        // R2 wrong address (other strap's) and read bit
        write_txn(addr_byte(1'b0, 1'b0), 8'h00, 8'h00, 3, 1'b0, "R2 other addr");
        write_txn(addr_byte(1'b1, 1'b1), 8'h00, 8'h00, 3, 1'b0, "R2 read bit");

        // R6 stop after command: shut taken, code kept
        write_txn(addr_byte(1'b1, 1'b0), 8'h80, 8'hFF, 2, 1'b1, "R6 stop after cmd");
        // R8 shut flag drives suspend
        chk("R8 suspend from flag", {31'd0, suspend}, 32'd1);
        chk("R8 regoff from flag", {31'd0, regoff}, 32'd1);
        write_txn(addr_byte(1'b1, 1'b0), 8'h00, 8'h00, 1, 1'b1, "R6 stop after addr");
        write_txn(addr_byte(1'b1, 1'b0), 8'h00, 8'h04, 3, 1'b1, "R4 clear shut");
        chk("R8 resume", {31'd0, suspend}, 32'd0);

        // R8 suspend pin with code retained
        sus_n = 1'b0;
        cyc(10);
        chk("R8 pin suspend", {31'd0, suspend}, 32'd1);
        chk("R8 pin regoff", {31'd0, regoff}, 32'd1);
        chk("R8 code retained", {26'd0, code}, {26'd0, exp_code});
        sus_n = 1'b1;
        cyc(10);
        chk("R8 pin release", {31'd0, regoff}, 32'd0);

        // R7 repeated start in the middle of a data byte
        bus_start();
        send_byte(addr_byte(1'b1, 1'b0), -1, a);
        send_byte(8'h00, -1, a);
        sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(2 * Q); scl_m = 1'b0;
        sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(2 * Q); scl_m = 1'b0;
        sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b0; cyc(Q); scl_m = 1'b0; cyc(Q);
        exp_shut = 1'b0;
        check_state("R7 partial discarded");
        send_byte(addr_byte(1'b1, 1'b0), -1, a);
        chk("R7 new addr ack", {31'd0, a}, 32'd1);
        send_byte(8'h01, -1, a);
        send_byte(8'hC3, -1, a);
        exp_code = 6'h30;
        // R10 extra byte after the data byte is not acknowledged
        send_byte(8'hFC, -1, a);
        chk("R10 extra byte no ack", {31'd0, a}, 32'd0);
        bus_stop();
        check_state("R10 extra byte ignored");

        // R9 short glitches on both lines inside the data byte
        bus_start();
        send_byte(addr_byte(1'b1, 1'b0), -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'h9C, 5, a);
        chk("R9 data ack with glitch", {31'd0, a}, 32'd1);
        exp_code = 6'h27;
        bus_stop();
        check_state("R9 glitch ignored");

        // R1 R2 strap 0 address and default
        do_reset(1'b0);
        check_state("R1 strap0 default");
        write_txn(addr_byte(1'b1, 1'b0), 8'h00, 8'hFF, 3, 1'b0, "R2 strap0 rejects 5A");
        write_txn(addr_byte(1'b0, 1'b0), 8'h00, 8'h57, 3, 1'b1, "R2 strap0 write");

        // Random mix
        for (int n = 0; n < 24; n++) begin
            cb = 8'($urandom());
            db = 8'($urandom());
            sp = 1 + int'($urandom() % 3);
            case ($urandom() % 4)
                0: ab = addr_byte(1'b1, 1'b0);
                1: ab = addr_byte(1'b0, 1'b1);
                default: ab = addr_byte(1'b0, 1'b0);
            endcase
            hit = (ab == addr_byte(1'b0, 1'b0));
            write_txn(ab, cb, db, sp, hit, "R5 random");
            chk("R8 random suspend", {31'd0, suspend}, {31'd0, exp_shut});
        end

        report();
        $finish;
    end
endmodule